// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block sits beside a small 8-bit controller core and decides, on every oscillator clock, whether the core runs, idles or sleeps. It drives the enable for the divided CPU clock, the enable for the divided peripheral clock and the enable for the oscillator itself. It also turns a noisy reset pin into a qualified system reset, and it supplies the levels that the address-latch strobe, the program-fetch strobe and the ports take while a low-power mode is active.

Software sets one of two request bits in a control register outside the block. From run, a sleep request stops the oscillator and a doze request stops only the CPU clock. A doze ends on any enabled pending interrupt. A sleep ends only through a qualified reset. On every exit from doze or sleep the block pulses a clear strobe so that the owning register drops both request bits. The oscillator is modelled as its enable only. Both derived clocks come from a divide-by-two phase. The block runs on the oscillator clock, and the bench treats that clock as free-running.

Top module: `pmc_top`

## Requirements
- R1: `sys_rst_o` rises after the 24th consecutive rising clock edge at which `rst_pin_i` is sampled high while the oscillator is enabled. A high pulse of 23 edges, or a pulse broken by one low sample, leaves `sys_rst_o` low.
- R2: After any reset, and while the pin stays high, `sys_rst_o` is 1, `mode_o` is 2'b11, and both clock enables are 0. The block enters run (`mode_o` = 2'b00) at the first edge where the pin is sampled low.
- R3: A doze request (`idl_req_i`) in run gives `mode_o` = 2'b01. In doze `cpu_ce_o` stays 0 and `per_ce_o` keeps pulsing on every second clock.
- R4: A sleep request (`pd_req_i`) in run gives `mode_o` = 2'b10, with `osc_en_o` and both clock enables at 0. When both requests are set together, sleep wins.
- R5: A pending interrupt in doze returns the block to run at the next edge. In the same cycle that `mode_o` shows run, `req_clr_o` is high for exactly one cycle.
- R6: In sleep, `irq_pend_i` has no effect. A high reset pin sets `osc_en_o` one edge later, and qualification counts only from then, so `sys_rst_o` rises after the 25th high edge.
- R7: In doze, `pin_ovr_o`, `ale_o` and `psen_o` are all 1. In sleep, `pin_ovr_o` is 1 and both strobes are 0. In run, `pin_ovr_o` is 0 and both strobes are at their idle level of 1.
- R8: With `ext_prog_i` = 1, `p0_float_o` is 1 in both doze and sleep, and `p2_addr_o` is 1 in doze only. With `ext_prog_i` = 0, both are 0 in every mode.
- R9: In run, `cpu_ce_o` and `per_ce_o` are each high on exactly half of the oscillator clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk_i | input | 1 | Oscillator clock |
| rst_pin_i | input | 1 | Raw reset pin, active high |
| idl_req_i | input | 1 | Doze request bit from control register |
| pd_req_i | input | 1 | Sleep request bit from control register |
| irq_pend_i | input | 1 | Some enabled interrupt is pending |
| ext_prog_i | input | 1 | Program memory is external |
| sys_rst_o | output | 1 | Qualified system reset |
| mode_o | output | 2 | 00 run, 01 doze, 10 sleep, 11 reset |
| req_clr_o | output | 1 | One-cycle strobe clearing both request bits |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_ce_o | output | 1 | CPU clock enable (divided by two) |
| per_ce_o | output | 1 | Peripheral clock enable (divided by two) |
| pin_ovr_o | output | 1 | Pin levels below override the core |
| ale_o | output | 1 | Forced address-latch strobe level |
| psen_o | output | 1 | Forced program-fetch strobe level |
| p0_float_o | output | 1 | Low address/data port released to high impedance |
| p2_addr_o | output | 1 | High port keeps driving the address instead of latch data |

## Verification
The bench builds the block with its default parameters: 12 clocks per machine cycle and 2 machine cycles of reset. This places the qualification threshold at 24 edges, so the 23/24 boundary and the 25-edge wake from sleep can be hit exactly in a short run. With these values, a full reset and re-entry into every mode fits in a few dozen cycles. That lets the table reset the block before each of the seven request and memory combinations.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    M_RUN  = 2'b00,
    M_IDLE = 2'b01,
    M_PDN  = 2'b10,
    M_RST  = 2'b11
  } pmode_e;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int MC_OSC   = 12,
  parameter int MC_COUNT = 2
) (
  input  logic clk,
  input  logic pin_i,
  input  logic osc_run_i,
  output logic hit_o
);
  localparam int THR = MC_OSC * MC_COUNT;
  localparam int CW  = $clog2(THR + 1);

  logic [CW-1:0] cnt_q = '0;

  always_ff @(posedge clk) begin
    if (!pin_i) cnt_q <= '0;
    else if (osc_run_i && cnt_q != CW'(THR)) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = pin_i && osc_run_i && (cnt_q == CW'(THR - 1));

  // R1: the run-length counter never passes the threshold
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!pin_i)
    cnt_q <= CW'(THR));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic   clk,
  input  logic   pin_i,
  input  logic   hit_i,
  input  logic   idl_req_i,
  input  logic   pd_req_i,
  input  logic   irq_i,
  output pmode_e state_o,
  output pmode_e nxt_o,
  output logic   clr_o
);
  pmode_e state_q = M_RST;
  pmode_e nxt;
  logic   clr_q = 1'b0;

  always_comb begin
    nxt = state_q;
    if (hit_i) nxt = M_RST;
    else begin
      unique case (state_q)
        M_RST:  if (!pin_i) nxt = M_RUN;
        M_RUN: begin
          if (!clr_q && pd_req_i)       nxt = M_PDN;
          else if (!clr_q && idl_req_i) nxt = M_IDLE;
        end
        M_IDLE: if (irq_i) nxt = M_RUN;
        M_PDN:  nxt = M_PDN;
        default: nxt = M_RST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state_q <= nxt;
    clr_q   <= (state_q == M_IDLE || state_q == M_PDN) && (nxt != state_q);
  end

  assign state_o = state_q;
  assign nxt_o   = nxt;
  assign clr_o   = clr_q;

  // R6: sleep holds while the reset pin is low, whatever the interrupt does
  p_pd_sticky_r6: assert property (@(posedge clk) disable iff (pin_i)
    state_q == M_PDN |=> state_q == M_PDN);
  // R5: a pending interrupt in doze returns to run with a clear strobe
  p_idle_wake_r5: assert property (@(posedge clk) disable iff (pin_i)
    (state_q == M_IDLE && irq_i) |=> (state_q == M_RUN && clr_q));
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pmc_pkg::*;
(
  input  logic   clk,
  input  logic   pin_i,
  input  pmode_e state_i,
  input  pmode_e nxt_i,
  output logic   osc_en_o,
  output logic   cpu_ce_o,
  output logic   per_ce_o
);
  logic osc_en_q = 1'b1;
  logic ph_q     = 1'b0;
  logic cpu_q    = 1'b0;
  logic per_q    = 1'b0;

  always_ff @(posedge clk) begin
    osc_en_q <= (nxt_i != M_PDN) || pin_i;
    if (osc_en_q) ph_q <= ~ph_q;
    cpu_q <= osc_en_q && !ph_q && (nxt_i == M_RUN);
    per_q <= osc_en_q && !ph_q && (nxt_i == M_RUN || nxt_i == M_IDLE);
  end

  assign osc_en_o = osc_en_q;
  assign cpu_ce_o = cpu_q;
  assign per_ce_o = per_q;

  // R3: no CPU clock outside run
  p_cpu_gated_r3: assert property (@(posedge clk) disable iff (state_i == M_RST)
    state_i != M_RUN |-> !cpu_q);
  // R4: oscillator stays off in sleep while the pin is low
  p_osc_off_r4: assert property (@(posedge clk) disable iff (state_i == M_RST)
    (state_i == M_PDN && !pin_i) |=> !osc_en_q);
endmodule

// File: rtl/pmc_pin_ovr.sv
module pmc_pin_ovr
  import pmc_pkg::*;
(
  input  logic   clk,
  input  pmode_e state_i,
  input  pmode_e nxt_i,
  input  logic   ext_i,
  output logic   ovr_o,
  output logic   ale_o,
  output logic   psen_o,
  output logic   p0f_o,
  output logic   p2a_o
);
  logic ovr_q  = 1'b0;
  logic ale_q  = 1'b1;
  logic psen_q = 1'b1;
  logic p0f_q  = 1'b0;
  logic p2a_q  = 1'b0;
  logic low_pwr, in_pd;

  assign in_pd   = (nxt_i == M_PDN);
  assign low_pwr = (nxt_i == M_IDLE) || in_pd;

  always_ff @(posedge clk) begin
    ovr_q  <= low_pwr;
    ale_q  <= !in_pd;
    psen_q <= !in_pd;
    p0f_q  <= ext_i && low_pwr;
    p2a_q  <= ext_i && (nxt_i == M_IDLE);
  end

  assign ovr_o  = ovr_q;
  assign ale_o  = ale_q;
  assign psen_o = psen_q;
  assign p0f_o  = p0f_q;
  assign p2a_o  = p2a_q;

  // R7: both strobes low whenever sleep is active
  p_pd_strobes_r7: assert property (@(posedge clk) disable iff (state_i == M_RST)
    state_i == M_PDN |-> (ovr_q && !ale_q && !psen_q));
  // R8: port 2 never drives the address in sleep
  p_p2_pd_r8: assert property (@(posedge clk) disable iff (state_i == M_RST)
    state_i == M_PDN |-> !p2a_q);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int MC_OSC   = 12,
  parameter int MC_COUNT = 2
) (
  input  logic       osc_clk_i,
  input  logic       rst_pin_i,
  input  logic       idl_req_i,
  input  logic       pd_req_i,
  input  logic       irq_pend_i,
  input  logic       ext_prog_i,
  output logic       sys_rst_o,
  output logic [1:0] mode_o,
  output logic       req_clr_o,
  output logic       osc_en_o,
  output logic       cpu_ce_o,
  output logic       per_ce_o,
  output logic       pin_ovr_o,
  output logic       ale_o,
  output logic       psen_o,
  output logic       p0_float_o,
  output logic       p2_addr_o
);
  logic   hit;
  pmode_e state, nxt;

  pmc_rst_qual #(.MC_OSC(MC_OSC), .MC_COUNT(MC_COUNT)) u_qual (
    .clk(osc_clk_i), .pin_i(rst_pin_i), .osc_run_i(osc_en_o), .hit_o(hit));

  pmc_fsm u_fsm (
    .clk(osc_clk_i), .pin_i(rst_pin_i), .hit_i(hit), .idl_req_i(idl_req_i),
    .pd_req_i(pd_req_i), .irq_i(irq_pend_i), .state_o(state), .nxt_o(nxt),
    .clr_o(req_clr_o));

  pmc_clk_gate u_cg (
    .clk(osc_clk_i), .pin_i(rst_pin_i), .state_i(state), .nxt_i(nxt),
    .osc_en_o(osc_en_o), .cpu_ce_o(cpu_ce_o), .per_ce_o(per_ce_o));

  pmc_pin_ovr u_pins (
    .clk(osc_clk_i), .state_i(state), .nxt_i(nxt), .ext_i(ext_prog_i),
    .ovr_o(pin_ovr_o), .ale_o(ale_o), .psen_o(psen_o), .p0f_o(p0_float_o),
    .p2a_o(p2_addr_o));

  assign sys_rst_o = (state == M_RST);
  assign mode_o    = state;
endmodule

// File: tb/pmc_top_tb_top.sv
module pmc_top_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic pin = 1'b1, idl = 1'b0, pd = 1'b0, irq = 1'b0, ext = 1'b0;
  logic sys_rst, req_clr, osc_en, cpu_ce, per_ce, ovr, ale, psen, p0f, p2a;
  logic [1:0] mode;
  int errs = 0, nchk = 0;

  always #(CLK_P/2) clk = ~clk;

  pmc_top dut_i (
    .osc_clk_i(clk), .rst_pin_i(pin), .idl_req_i(idl), .pd_req_i(pd),
    .irq_pend_i(irq), .ext_prog_i(ext), .sys_rst_o(sys_rst), .mode_o(mode),
    .req_clr_o(req_clr), .osc_en_o(osc_en), .cpu_ce_o(cpu_ce), .per_ce_o(per_ce),
    .pin_ovr_o(ovr), .ale_o(ale), .psen_o(psen), .p0_float_o(p0f),
    .p2_addr_o(p2a));

  // {pd, idl, ext, mode[1:0], ovr, ale, psen, p0f, p2a, osc_en}
  localparam logic [10:0] VEC [0:6] = '{
    11'b000_00_011001,
    11'b010_01_111001,
    11'b011_01_111111,
    11'b100_10_100000,
    11'b101_10_100100,
    11'b111_10_100100,
    11'b110_10_100000
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    pin = 1'b1;
    repeat (30) @(negedge clk);
    pin = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic enter(input logic p, input logic i);
    pd = p; idl = i;
    @(negedge clk);
    pd = 1'b0; idl = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic count_ce(input int n, output int nc, output int np);
    nc = 0; np = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      nc += int'(cpu_ce); np += int'(per_ce);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    int nc, np;
    // R2: reset state while the pin is held
    repeat (30) @(negedge clk);
    chk("R2 sys_rst", sys_rst, 1);
    chk("R2 mode", mode, 3);
    chk("R2 cpu_ce", cpu_ce, 0);
    pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 run after release", mode, 0);

    // R9: run clock rate
    count_ce(20, nc, np);
    chk("R9 cpu_ce count", nc, 10);
    chk("R9 per_ce count", np, 10);

    // R4 R7 R8: table of request and memory combinations
    for (int v = 0; v < 7; v++) begin
      logic [10:0] e;
      e = VEC[v];
      do_reset();
      ext = e[8];
      @(negedge clk);
      enter(e[10], e[9]);
      chk($sformatf("R4 mode v%0d", v), mode, int'(e[7:6]));
      chk($sformatf("R7 ovr v%0d", v), ovr, int'(e[5]));
      chk($sformatf("R7 ale v%0d", v), ale, int'(e[4]));
      chk($sformatf("R7 psen v%0d", v), psen, int'(e[3]));
      chk($sformatf("R8 p0 float v%0d", v), p0f, int'(e[2]));
      chk($sformatf("R8 p2 addr v%0d", v), p2a, int'(e[1]));
      chk($sformatf("R4 osc_en v%0d", v), osc_en, int'(e[0]));
    end
    ext = 1'b0;

    // R1: 23-edge pulse ignored, 24th edge qualifies
    do_reset();
    pin = 1'b1;
    repeat (23) @(negedge clk);
    chk("R1 23 edges", sys_rst, 0);
    @(negedge clk);
    chk("R1 24 edges", sys_rst, 1);
    pin = 1'b0;
    repeat (2) @(negedge clk);
    // R1: broken pulse ignored
    pin = 1'b1;
    repeat (20) @(negedge clk);
    pin = 1'b0;
    @(negedge clk);
    pin = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 broken pulse", sys_rst, 0);
    pin = 1'b0;
    @(negedge clk);

    // R3: doze keeps peripheral clock only
    enter(1'b0, 1'b1);
    count_ce(20, nc, np);
    chk("R3 cpu_ce in doze", nc, 0);
    chk("R3 per_ce in doze", np, 10);
    // R5: interrupt wake with clear strobe
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    chk("R5 mode after irq", mode, 0);
    chk("R5 req_clr pulse", req_clr, 1);
    @(negedge clk);
    chk("R5 req_clr single", req_clr, 0);

    // R4: sleep gates everything
    enter(1'b1, 1'b0);
    count_ce(10, nc, np);
    chk("R4 cpu_ce in sleep", nc, 0);
    chk("R4 per_ce in sleep", np, 0);
    // R6: interrupt ignored in sleep
    irq = 1'b1;
    repeat (5) @(negedge clk);
    irq = 1'b0;
    chk("R6 mode after irq", mode, 2);
    chk("R6 osc stays off", osc_en, 0);
    // R6: wake by reset needs 25 edges
    pin = 1'b1;
    @(negedge clk);
    chk("R6 osc restart", osc_en, 1);
    repeat (23) @(negedge clk);
    chk("R6 24 edges from sleep", sys_rst, 0);
    @(negedge clk);
    chk("R6 25 edges from sleep", sys_rst, 1);
    pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 run after sleep reset", mode, 0);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule